// File: doc/BRIEF.md
# Sized Integer Add/Subtract Unit with Status Flags

This block performs one of eight two's-complement integer operations on an operand width picked per operation: 8, 16 or 32 bits. The eight operations are plain add, add with carry-in, plain subtract, subtract with borrow-in, increment, decrement, compare and negate. From the sized result the unit derives six status flags: carry, parity, auxiliary carry, zero, sign and overflow. For each flag it also produces its own update enable. A separate write enable tells the surrounding datapath whether the destination operand should take the result.

The arithmetic core is combinational. A thin wrapper stores the six flags in a register that loads on each valid operation, and only the bits whose enable is set are loaded. The stored carry feeds back as the carry or borrow input of the chained operations, so multi-word sums and differences can be built from a sequence of operations. Operand fetch, instruction decode, decimal adjust and branching stay outside the block.

Top module: `addsub_flag_unit`

## Requirements
- R1: `sizeSel` picks the operand width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Only the low bits of each operand up to that width are used. Result bits above the width read zero, and every flag is taken from the selected width only. For example, an 8-bit add of 200 and 100 gives 44 with carry set.
- R2: `opCode` 0 adds; opCode 1 adds, plus one more when the stored carry flag is 1. Carry is the carry out of the top bit of the selected width.
- R3: `opCode` 2 subtracts source from destination; opCode 3 does the same and subtracts one more when the stored carry flag is 1. For all subtract-type operations (2, 3, 6, 7), carry is set when a borrow out of the top bit occurs.
- R4: `opCode` 4 adds one to the destination and opCode 5 subtracts one from it. Both update parity, auxiliary carry, zero, sign and overflow, and neither updates carry (flagWe bit 0 is 0), so the stored carry keeps its value.
- R5: `opCode` 6 computes destination minus source and updates all six flags, and `destWe` stays 0.
- R6: `opCode` 7 gives zero minus the destination and updates all six flags. Negating zero clears carry, and any nonzero value sets it. Negating the most negative value of the width returns that same value and sets overflow.
- R7: Sign equals the top bit of the sized result. Zero is 1 exactly when the sized result is all zeros.
- R8: Overflow is 1 when the exact signed result lies outside the two's-complement range of the selected width.
- R9: Auxiliary carry is the carry (add-type) or borrow (subtract-type) out of bit 3. Parity is 1 when bits 7:0 of the result hold an even number of ones.
- R10: Flag vectors use bit positions 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign, 5 overflow. The stored flags reset to 0. On a rising clock edge with `opValid` high, each stored bit whose `flagWe` bit is set loads from `flagNew`. With `opValid` low, `flagWe` and `destWe` are 0 and the stored flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Operation select (see R2 to R6) |
| sizeSel | input | 2 | Operand width select (see R1) |
| dstVal | input | 32 | Destination operand |
| srcVal | input | 32 | Source operand |
| result | output | 32 | Sized result, zero above the selected width |
| destWe | output | 1 | Destination write enable |
| flagNew | output | 6 | Freshly computed flags |
| flagWe | output | 6 | Per-flag update enables |
| flagQ | output | 6 | Stored flags |

## Verification
The bench targets the width boundaries. An 8-bit carry taken from bit 32 instead of bit 8 would be missed, and a sign bit read from the wrong position would give wrong sign and overflow at 16 bits. It chains add-with-carry and subtract-with-borrow behind operations that leave carry set, so an unused carry-in would show up as results that are off by one. Increment of 0xFF after a borrow catches any design that clears the kept carry. It also checks negate of zero and of the most negative value: a carry rule inverted for negate, or overflow computed with add-type polarity, gives a wrong flag there.

// File: rtl/addsub_flag_pkg.sv
package addsub_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_INC = 3'd4,
    OP_DEC = 3'd5,
    OP_CMP = 3'd6,
    OP_NEG = 3'd7
  } addsub_op_e;

  localparam int FLAG_N  = 6;
  localparam int FLAG_CF = 0;
  localparam int FLAG_PF = 1;
  localparam int FLAG_AF = 2;
  localparam int FLAG_ZF = 3;
  localparam int FLAG_SF = 4;
  localparam int FLAG_OF = 5;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic subtract;   // a - b instead of a + b
    logic useCarry;   // fold stored carry into the operation
    logic constOne;   // second operand is the constant one
    logic zeroFirst;  // first operand is zero, destination becomes second
  } addsub_ctrl_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_flag_pkg::*;
(
  input  logic                opValid,
  input  addsub_op_e          opSel,
  output addsub_ctrl_t        ctrl,
  output logic                destWe,
  output logic [FLAG_N-1:0]   flagWe
);

  always_comb begin
    ctrl   = '0;
    destWe = opValid;
    flagWe = opValid ? {FLAG_N{1'b1}} : '0;
    unique case (opSel)
      OP_ADD: ;
      OP_ADC: ctrl.useCarry = 1'b1;
      OP_SUB: ctrl.subtract = 1'b1;
      OP_SBB: begin
        ctrl.subtract = 1'b1;
        ctrl.useCarry = 1'b1;
      end
      OP_INC: begin
        ctrl.constOne = 1'b1;
        flagWe[FLAG_CF] = 1'b0;
      end
      OP_DEC: begin
        ctrl.constOne = 1'b1;
        ctrl.subtract = 1'b1;
        flagWe[FLAG_CF] = 1'b0;
      end
      OP_CMP: begin
        ctrl.subtract = 1'b1;
        destWe = 1'b0;
      end
      OP_NEG: begin
        ctrl.subtract  = 1'b1;
        ctrl.zeroFirst = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  addsub_ctrl_t        ctrl,
  input  logic [1:0]          sizeSel,
  input  logic [DATA_W-1:0]   dstVal,
  input  logic [DATA_W-1:0]   srcVal,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   result,
  output logic [FLAG_N-1:0]   flagNew
);

  localparam int LANE_N  = 3;
  localparam int QUART_W = DATA_W / 4;

  logic [LANE_N-1:0]  laneCarry, laneSignA, laneSignB, laneSignR;
  logic [DATA_W-1:0]  laneMask [LANE_N];
  logic [1:0]         laneIdx;
  logic [DATA_W-1:0]  widthMask, opA, opB;
  logic [DATA_W:0]    sumFull;
  logic               ci, signA, signB, signR;

  assign laneIdx   = (sizeSel == 2'd3) ? 2'd2 : sizeSel;
  assign widthMask = laneMask[laneIdx];

  assign opA = ctrl.zeroFirst ? '0 : (dstVal & widthMask);
  assign opB = ctrl.constOne  ? DATA_W'(1)
             : ((ctrl.zeroFirst ? dstVal : srcVal) & widthMask);
  assign ci  = ctrl.useCarry & carryIn;

  always_comb begin
    if (ctrl.subtract)
      sumFull = {1'b0, opA} - {1'b0, opB} - (DATA_W + 1)'(ci);
    else
      sumFull = {1'b0, opA} + {1'b0, opB} + (DATA_W + 1)'(ci);
  end

  assign result = sumFull[DATA_W-1:0] & widthMask;

  // one tap set per supported width: 1/4, 1/2 and full data width
  for (genvar g = 0; g < LANE_N; g++) begin : g_lane
    localparam int LW = QUART_W << g;
    assign laneMask[g]  = {{(DATA_W - LW){1'b0}}, {LW{1'b1}}};
    assign laneCarry[g] = sumFull[LW];
    assign laneSignA[g] = opA[LW-1];
    assign laneSignB[g] = opB[LW-1];
    assign laneSignR[g] = sumFull[LW-1];
  end

  assign signA = laneSignA[laneIdx];
  assign signB = laneSignB[laneIdx];
  assign signR = laneSignR[laneIdx];

  always_comb begin
    flagNew          = '0;
    flagNew[FLAG_CF] = laneCarry[laneIdx];
    flagNew[FLAG_PF] = ~^result[7:0];
    flagNew[FLAG_AF] = opA[4] ^ opB[4] ^ sumFull[4];
    flagNew[FLAG_ZF] = (result == '0);
    flagNew[FLAG_SF] = signR;
    flagNew[FLAG_OF] = ctrl.subtract ? ((signA != signB) && (signR != signA))
                                     : ((signA == signB) && (signR != signA));
  end

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_flag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcVal,
  output logic [DATA_W-1:0] result,
  output logic              destWe,
  output logic [5:0]        flagNew,
  output logic [5:0]        flagWe,
  output logic [5:0]        flagQ
);

  localparam int QUART_W = DATA_W / 4;

  addsub_op_e   opSel;
  addsub_ctrl_t ctrl;

  assign opSel = addsub_op_e'(opCode);

  addsub_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .ctrl    (ctrl),
    .destWe  (destWe),
    .flagWe  (flagWe)
  );

  addsub_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl    (ctrl),
    .sizeSel (sizeSel),
    .dstVal  (dstVal),
    .srcVal  (srcVal),
    .carryIn (flagQ[FLAG_CF]),
    .result  (result),
    .flagNew (flagNew)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      for (int i = 0; i < FLAG_N; i++)
        if (flagWe[i]) flagQ[i] <= flagNew[i];
    end
  end

  // R4: stepping by one never disturbs the stored carry
  a_r4_carry_held: assert property (@(posedge clk) disable iff (!rstN)
    opValid && (opSel == OP_INC || opSel == OP_DEC)
      |=> flagQ[FLAG_CF] == $past(flagQ[FLAG_CF]));

  // R5: compare writes flags but not the destination
  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_CMP |-> !destWe && flagWe == 6'h3f);

  // R10: idle cycles leave the stored flags alone
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagQ));

  // R1: byte-wide results carry nothing above the byte
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    sizeSel == 2'd0 |-> result[DATA_W-1:QUART_W] == '0);

  // R7: zero flag agrees with the result bus
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> flagNew[FLAG_ZF] == (result == '0));

  // R6: negating zero yields zero without a borrow
  a_r6_neg_zero: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opSel == OP_NEG && dstVal == '0
      |-> result == '0 && !flagNew[FLAG_CF]);

endmodule

// File: tb/addsub_flag_unit_test.sv
module addsub_flag_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  sizeSel = '0;
  logic [31:0] dstVal = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] result;
  logic        destWe;
  logic [5:0]  flagNew, flagWe, flagQ;

  int testCnt = 0;
  int failCnt = 0;
  logic [5:0] mFlags = '0;

  always #10 clk = ~clk;

  addsub_flag_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .sizeSel(sizeSel), .dstVal(dstVal), .srcVal(srcVal),
    .result(result), .destWe(destWe), .flagNew(flagNew),
    .flagWe(flagWe), .flagQ(flagQ)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string opTag(input int op);
    case (op)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6:       return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic runOp(input int op, input int sz, input logic [31:0] d,
                       input logic [31:0] s, input bit v, input string tag);
    int w;
    longint mask, a, b, cin, full, r, sa, sb, sr, la, lb, half;
    bit sub, cf, of, af, pf, zf, sf;
    logic [5:0] expNew, expWe;
    bit expDest;
    @(negedge clk);
    opValid = v; opCode = 3'(op); sizeSel = 2'(sz); dstVal = d; srcVal = s;
    #2;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'sd1 <<< w) - 1;
    a = d; b = s; cin = 0; sub = 0;
    case (op)
      1: cin = mFlags[0];
      2: sub = 1;
      3: begin sub = 1; cin = mFlags[0]; end
      4: b = 1;
      5: begin b = 1; sub = 1; end
      6: sub = 1;
      7: begin a = 0; b = d; sub = 1; end
      default: ;
    endcase
    a = a & mask; b = b & mask;
    full = sub ? (a - b - cin) : (a + b + cin);
    r = full & mask;
    cf = sub ? (full < 0) : (full > mask);
    half = 64'sd1 <<< (w - 1);
    sa = (a >= half) ? a - (half * 2) : a;
    sb = (b >= half) ? b - (half * 2) : b;
    sr = sub ? (sa - sb - cin) : (sa + sb + cin);
    of = (sr > half - 1) || (sr < -half);
    la = a & 15; lb = b & 15;
    af = sub ? ((la - lb - cin) < 0) : ((la + lb + cin) > 15);
    pf = ($countones(r[7:0]) % 2) == 0;
    zf = (r == 0);
    sf = ((r >>> (w - 1)) & 1) != 0;
    expNew  = {of, sf, zf, af, pf, cf};
    expWe   = !v ? 6'h00 : ((op == 4 || op == 5) ? 6'h3e : 6'h3f);
    expDest = v && (op != 6);
    check(result == 32'(r), tag, "result", result, 32'(r));
    check((flagNew & expWe) == (expNew & expWe), tag, "flags",
          flagNew & expWe, expNew & expWe);
    check(flagWe == expWe, v ? tag : "R10", "flagWe", flagWe, expWe);
    check(destWe == expDest, (op == 6) ? "R5" : "R10", "destWe", destWe, expDest);
    check(flagQ == mFlags, "R10", "flagQ", flagQ, mFlags);
    @(posedge clk);
    if (v) mFlags = (mFlags & ~expWe) | (expNew & expWe);
  endtask

  initial begin
    #4000000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flagQ == 6'h00, "R10", "reset flagQ", flagQ, 0);
    rstN = 1'b1;
    // R1: 8-bit carry at 255, upper operand bits ignored
    runOp(0, 0, 32'h1234_56C8, 32'hABCD_EF64, 1, "R1");
    runOp(0, 1, 32'h0000_FFFF, 32'h0000_0001, 1, "R1");
    runOp(0, 3, 32'hFFFF_FFFF, 32'h0000_0001, 1, "R1");
    // R2: carry chain
    runOp(1, 1, 32'h0, 32'h0, 1, "R2");
    runOp(0, 2, 32'h8000_0000, 32'h8000_0000, 1, "R2");
    runOp(1, 2, 32'h1, 32'h2, 1, "R2");
    // R3: borrow chain
    runOp(2, 0, 32'h5, 32'h6, 1, "R3");
    runOp(3, 0, 32'h0, 32'h0, 1, "R3");
    runOp(3, 1, 32'h10, 32'h1, 1, "R3");
    // R4: carry kept through increment and decrement
    runOp(2, 0, 32'h0, 32'h1, 1, "R4");
    runOp(4, 0, 32'hFF, 32'h0, 1, "R4");
    runOp(5, 0, 32'h0, 32'h0, 1, "R4");
    runOp(4, 1, 32'h7FFF, 32'h0, 1, "R4");
    // R5: compare
    runOp(6, 2, 32'h10, 32'h20, 1, "R5");
    runOp(6, 0, 32'h33, 32'h33, 1, "R5");
    // R6: negate corners
    runOp(7, 0, 32'h0, 32'h0, 1, "R6");
    runOp(7, 0, 32'h80, 32'h0, 1, "R6");
    runOp(7, 2, 32'h8000_0000, 32'h0, 1, "R6");
    runOp(7, 1, 32'h1, 32'h0, 1, "R6");
    // R7 / R8: sign and overflow at each width
    runOp(0, 0, 32'h7F, 32'h1, 1, "R8");
    runOp(2, 0, 32'h80, 32'h1, 1, "R8");
    runOp(0, 1, 32'h8000, 32'h8000, 1, "R8");
    runOp(2, 2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, "R8");
    runOp(0, 1, 32'h4000, 32'h0001, 1, "R7");
    // R9: nibble carry/borrow and parity
    runOp(0, 0, 32'h0F, 32'h01, 1, "R9");
    runOp(2, 0, 32'h10, 32'h01, 1, "R9");
    runOp(0, 0, 32'h02, 32'h01, 1, "R9");
    // R10: idle cycles with junk inputs
    runOp(2, 0, 32'h0, 32'h1, 0, "R10");
    runOp(7, 2, 32'h5, 32'h9, 0, "R10");
    for (int k = 0; k < 3000; k++) begin
      int op, sz;
      bit v;
      op = $urandom_range(0, 7);
      sz = $urandom_range(0, 3);
      v  = ($urandom_range(0, 7) != 0);
      runOp(op, sz, $urandom, ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom,
            v, v ? opTag(op) : "R10");
    end
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule